// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block sits behind a data converter and watches its stream of 12-bit results. Each result arrives with a channel index and an end-of-conversion strobe. A separate start-of-conversion strobe marks the beginning of every conversion. When a result comes from a channel selected in the guard mask, the block compares it with a programmable low and high threshold. It keeps three indications of a result outside that window:

- a sticky flag that software clears;
- a level output that follows the most recent guarded result;
- a single-cycle interrupt pulse.

Software changes the thresholds, the guard mask and the interrupt enable through a simple register-write port. A threshold may be rewritten while a conversion is under way. That conversion is then excluded from checking, so a half-applied window cannot produce a false alarm. The new window governs the conversion that starts after the write. The level output is only ever changed by a checked conversion result, never by a threshold write.

Top module: `awd_monitor`

## Requirements
- R1: After reset the low threshold is 0, the high threshold is 0xFFF, every channel is guarded, the interrupt enable is off, and `awdFlag`, `awdOut` and `awdIrq` are all 0.
- R2: The comparison happens only in a cycle with `eocStb` high. A result is outside the window when it is strictly below the low threshold or strictly above the high threshold. A result equal to either threshold is inside.
- R3: At a checked guarded result, `awdOut` becomes 1 if the result is outside the window and 0 if it is inside, whatever the state of `awdFlag`. All outputs change on the clock edge that samples `eocStb`.
- R4: `awdFlag` is set by an outside guarded result. It then stays 1 until a cycle with `flagClr` high.
- R5: When `flagClr` is high in the same cycle as a result that sets the flag, the flag stays 1.
- R6: `awdIrq` is a one-cycle pulse after an outside guarded result, and only while the interrupt enable is 1.
- R7: A result whose channel has a 0 bit in the guard mask leaves `awdFlag`, `awdOut` and `awdIrq` unchanged.
- R8: A threshold write after the cycle with `socStb` and up to and including the cycle with `eocStb` masks that conversion. The conversion then causes no flag, no interrupt and no output change, even when the result lies outside the new window.
- R9: The mask is released by the next `socStb`. The new thresholds apply to that conversion. A threshold write in the same cycle as `socStb` does not mask the conversion it starts.
- R10: A threshold write never drives `awdOut` from 1 to 0.
- R11: The register map is selected by `regSel`:
  - 0 writes the low threshold, taken from `regWrData[11:0]`.
  - 1 writes the high threshold, taken from `regWrData[11:0]`.
  - 2 writes the guard mask, where bit n guards channel n.
  - 3 writes the control word, where bit 0 is the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| socStb | input | 1 | Start-of-conversion strobe |
| eocStb | input | 1 | End-of-conversion strobe; result and channel are valid |
| chanIdx | input | 4 | Channel of the result |
| resultData | input | 12 | Conversion result |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 low, 1 high, 2 guard mask, 3 control) |
| regWrData | input | 16 | Register write data |
| flagClr | input | 1 | Software clear of the sticky flag |
| awdFlag | output | 1 | Sticky out-of-window flag |
| awdOut | output | 1 | Watchdog level output |
| awdIrq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench drives several kinds of results and checks what each one tells apart:
- Results lying just below, exactly on and just above each threshold separate strict from inclusive comparison.
- Alternating outside and inside results, with and without an intermediate flag clear, separate the level output from the sticky flag.
- Conversions carrying a threshold write in the start cycle, in the middle or in the end cycle separate the masked case from the unmasked one. The follow-up conversion shows that the new window is then in force.
- Unguarded channels, a flag clear colliding with a new event, and a disabled interrupt isolate the gating paths.

// File: rtl/awd_pkg.sv
package awd_pkg;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_GUARD = 2'd2,
    SEL_CTRL  = 2'd3
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic hitOut;   // checked guarded result outside window
    logic hitIn;    // checked guarded result inside window
    logic clrFlag;  // software clear request
    logic fireIrq;  // interrupt pulse request
  } awdStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic guarded;
    logic outside;
    logic irqEn;
    logic thrWr;
  } awdCmp_t;

endpackage

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lowThr,
  input  logic [DATA_W-1:0] highThr,
  output logic              outside
);
  logic belowLow;
  logic aboveHigh;

  always_comb begin
    belowLow  = sample < lowThr;
    aboveHigh = sample > highThr;
    outside   = belowLow | aboveHigh;
  end
endmodule

// File: rtl/awd_datapath.sv
module awd_datapath
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [CH_W-1:0]   chanIdx,
  input  logic [DATA_W-1:0] resultData,
  input  awdStrb_t          strb,
  output awdCmp_t           cmp,
  output logic              awdFlag,
  output logic              awdOut,
  output logic              awdIrq
);
  localparam int IDX_SPAN = 1 << CH_W;

  logic [DATA_W-1:0]   lowThr;
  logic [DATA_W-1:0]   highThr;
  logic [NUM_CH-1:0]   guardMask;
  logic                irqEn;
  logic [IDX_SPAN-1:0] guardFull;
  logic                outsideNow;
  regSel_e             selNow;

  assign selNow = regSel_e'(regSel);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowThr    <= '0;
      highThr   <= '1;
      guardMask <= '1;
      irqEn     <= 1'b0;
    end else if (regWrEn) begin
      case (selNow)
        SEL_LOW:   lowThr    <= regWrData[DATA_W-1:0];
        SEL_HIGH:  highThr   <= regWrData[DATA_W-1:0];
        SEL_GUARD: guardMask <= regWrData[NUM_CH-1:0];
        SEL_CTRL:  irqEn     <= regWrData[0];
        default:   irqEn     <= irqEn;
      endcase
    end
  end

  // channel guard decode, indices past NUM_CH never guarded
  for (genvar g = 0; g < IDX_SPAN; g++) begin : g_guard
    if (g < NUM_CH) begin : g_real
      assign guardFull[g] = guardMask[g];
    end else begin : g_pad
      assign guardFull[g] = 1'b0;
    end
  end

  awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample  (resultData),
    .lowThr  (lowThr),
    .highThr (highThr),
    .outside (outsideNow)
  );

  always_comb begin
    cmp.guarded = guardFull[chanIdx];
    cmp.outside = outsideNow;
    cmp.irqEn   = irqEn;
    cmp.thrWr   = regWrEn & ((selNow == SEL_LOW) | (selNow == SEL_HIGH));
  end

  // watchdog state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      awdFlag <= 1'b0;
      awdOut  <= 1'b0;
      awdIrq  <= 1'b0;
    end else begin
      if (strb.hitOut)       awdFlag <= 1'b1;
      else if (strb.clrFlag) awdFlag <= 1'b0;

      if (strb.hitOut)     awdOut <= 1'b1;
      else if (strb.hitIn) awdOut <= 1'b0;

      awdIrq <= strb.fireIrq;
    end
  end
endmodule

// File: rtl/awd_control.sv
module awd_control
  import awd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     socStb,
  input  logic     eocStb,
  input  logic     flagClr,
  input  awdCmp_t  cmp,
  output awdStrb_t strb
);
  logic convBusy;
  logic convMask;
  logic maskedNow;
  logic evalNow;

  // a threshold write while busy, not in a start cycle, masks this conversion
  assign maskedNow = convMask | (cmp.thrWr & convBusy & ~socStb);
  assign evalNow   = eocStb & cmp.guarded & ~maskedNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convBusy <= 1'b0;
      convMask <= 1'b0;
    end else begin
      if (socStb)      convBusy <= 1'b1;
      else if (eocStb) convBusy <= 1'b0;

      if (socStb)      convMask <= 1'b0;
      else if (eocStb) convMask <= 1'b0;
      else             convMask <= maskedNow;
    end
  end

  always_comb begin
    strb.hitOut  = evalNow & cmp.outside;
    strb.hitIn   = evalNow & ~cmp.outside;
    strb.clrFlag = flagClr;
    strb.fireIrq = evalNow & cmp.outside & cmp.irqEn;
  end
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REG_W = (NUM_CH > DATA_W) ? NUM_CH : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              socStb,
  input  logic              eocStb,
  input  logic [CH_W-1:0]   chanIdx,
  input  logic [DATA_W-1:0] resultData,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              flagClr,
  output logic              awdFlag,
  output logic              awdOut,
  output logic              awdIrq
);
  awdStrb_t strb;
  awdCmp_t  cmp;

  awd_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .socStb  (socStb),
    .eocStb  (eocStb),
    .flagClr (flagClr),
    .cmp     (cmp),
    .strb    (strb)
  );

  awd_datapath #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .chanIdx    (chanIdx),
    .resultData (resultData),
    .strb       (strb),
    .cmp        (cmp),
    .awdFlag    (awdFlag),
    .awdOut     (awdOut),
    .awdIrq     (awdIrq)
  );
endmodule

// File: rtl/awd_monitor_chk.sv
module awd_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic eocStb,
  input logic flagClr,
  input logic awdFlag,
  input logic awdOut,
  input logic awdIrq
);
  // R2: the flag can only rise from a comparison at end of conversion
  a_r2_flag_rise_at_eoc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awdFlag) |-> $past(eocStb));

  // R3: the level output only moves after an end-of-conversion cycle
  a_r3_out_moves_at_eoc: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(awdOut) |-> $past(eocStb));

  // R4: the sticky flag only falls after a software clear
  a_r4_flag_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(awdFlag) |-> $past(flagClr));

  // R6: an interrupt pulse follows an end of conversion and comes with the flag
  a_r6_irq_after_eoc: assert property (@(posedge clk) disable iff (!rstN)
    awdIrq |-> ($past(eocStb) && awdFlag));

  // R10: without an end of conversion a high output stays high
  a_r10_out_held: assert property (@(posedge clk) disable iff (!rstN)
    (awdOut && !eocStb) |=> awdOut);
endmodule

bind awd_monitor awd_monitor_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .eocStb  (eocStb),
  .flagClr (flagClr),
  .awdFlag (awdFlag),
  .awdOut  (awdOut),
  .awdIrq  (awdIrq)
);

// File: tb/test_awd_monitor.sv
module test_awd_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        socStb = 1'b0;
  logic        eocStb = 1'b0;
  logic [3:0]  chanIdx = '0;
  logic [11:0] resultData = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic        flagClr = 1'b0;
  logic        awdFlag, awdOut, awdIrq;

  int total = 0;
  int bad = 0;
  bit summaryDone = 1'b0;

  // reference model
  logic [11:0] mLow = 12'h000;
  logic [11:0] mHigh = 12'hFFF;
  logic [15:0] mGuard = 16'hFFFF;
  bit mIrqEn = 1'b0;
  bit mFlag = 1'b0;
  bit mOut = 1'b0;

  logic [2:0] expQ[$];   // {out, flag, irq}
  string tagQ[$];
  bit sawEoc;

  always #4 clk = ~clk;  // 125 MHz

  awd_monitor i_awd_monitor (
    .clk(clk), .rstN(rstN), .socStb(socStb), .eocStb(eocStb),
    .chanIdx(chanIdx), .resultData(resultData), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .flagClr(flagClr),
    .awdFlag(awdFlag), .awdOut(awdOut), .awdIrq(awdIrq)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {out,flag,irq} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic printSummary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  function automatic void applyWr(input logic [1:0] sel, input logic [15:0] d);
    case (sel)
      2'd0: mLow = d[11:0];
      2'd1: mHigh = d[11:0];
      2'd2: mGuard = d;
      default: mIrqEn = d[0];
    endcase
  endfunction

  // register write outside any conversion (R11)
  task automatic wrReg(input logic [1:0] sel, input logic [15:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    applyWr(sel, d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic clrPulse();
    flagClr = 1'b1;
    mFlag = 1'b0;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  // one conversion: start cycle, middle cycle, end cycle
  // wrPhase: 0 none, 1 write in start cycle, 2 middle, 3 end cycle
  task automatic conv(input int ch, input logic [11:0] d, input int wrPhase,
                      input logic [1:0] wsel, input logic [15:0] wdata,
                      input bit clr, input string tag);
    bit masked, eval, outside, irq;
    socStb = 1'b1;
    if (wrPhase == 1) begin regWrEn = 1'b1; regSel = wsel; regWrData = wdata; applyWr(wsel, wdata); end
    @(negedge clk);
    socStb = 1'b0; regWrEn = 1'b0;
    if (wrPhase == 2) begin regWrEn = 1'b1; regSel = wsel; regWrData = wdata; applyWr(wsel, wdata); end
    @(negedge clk);
    regWrEn = 1'b0;
    eocStb = 1'b1; chanIdx = 4'(ch); resultData = d; flagClr = clr;
    if (wrPhase == 3) begin regWrEn = 1'b1; regSel = wsel; regWrData = wdata; applyWr(wsel, wdata); end
    masked  = (wrPhase == 2 || wrPhase == 3) && (wsel < 2'd2);
    eval    = mGuard[ch] && !masked;
    outside = (d < mLow) || (d > mHigh);
    irq     = eval && outside && mIrqEn;
    if (eval && outside) begin mOut = 1'b1; mFlag = 1'b1; end
    else begin
      if (eval) mOut = 1'b0;
      if (clr) mFlag = 1'b0;
    end
    expQ.push_back({mOut, mFlag, irq});
    tagQ.push_back(tag);
    @(negedge clk);
    eocStb = 1'b0; regWrEn = 1'b0; flagClr = 1'b0;
  endtask

  // monitor: compare one expected item per end-of-conversion
  initial begin
    forever begin
      @(posedge clk);
      sawEoc = eocStb;
      #2;
      if (sawEoc && rstN) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard: unexpected result, queue empty");
        end else begin
          chk(tagQ.pop_front(), {awdOut, awdFlag, awdIrq}, expQ.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    printSummary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {awdOut, awdFlag, awdIrq}, 3'b000);

    conv(0, 12'h800, 0, 2'd0, 16'h0, 1'b0, "R1 default window inside");
    conv(5, 12'hFFF, 0, 2'd0, 16'h0, 1'b0, "R1 default window top edge inside");

    wrReg(2'd0, 16'h0100);
    wrReg(2'd1, 16'h0E00);
    wrReg(2'd3, 16'h0001);

    conv(1, 12'h0FF, 0, 2'd0, 16'h0, 1'b0, "R2 below low outside");
    @(negedge clk);
    chk("R6 irq single cycle", {awdOut, awdFlag, awdIrq}, {mOut, mFlag, 1'b0});
    conv(1, 12'h100, 0, 2'd0, 16'h0, 1'b0, "R3 equal low inside, R4 flag kept");
    conv(1, 12'hE00, 0, 2'd0, 16'h0, 1'b0, "R2 equal high inside");
    conv(1, 12'hE01, 0, 2'd0, 16'h0, 1'b0, "R2 above high outside");

    clrPulse();
    chk("R4 flag cleared by software", {awdOut, awdFlag, awdIrq}, {1'b1, 1'b0, 1'b0});
    conv(2, 12'h500, 0, 2'd0, 16'h0, 1'b0, "R3 inside drops out");

    wrReg(2'd2, 16'hFFFE);
    conv(0, 12'h000, 0, 2'd0, 16'h0, 1'b0, "R7 unguarded channel ignored");
    conv(2, 12'h000, 0, 2'd0, 16'h0, 1'b0, "R7 guarded channel checked");
    wrReg(2'd0, 16'h0000);
    chk("R10 idle threshold write keeps out", {awdOut, awdFlag, awdIrq}, 3'b110);
    wrReg(2'd0, 16'h0100);

    conv(3, 12'h800, 0, 2'd0, 16'h0, 1'b1, "R3 inside with clear");
    conv(3, 12'hA00, 2, 2'd1, 16'h0900, 1'b0, "R8 mid write masks");
    conv(3, 12'hA00, 0, 2'd0, 16'h0, 1'b0, "R9 new window applies next");
    clrPulse();
    conv(3, 12'h800, 0, 2'd0, 16'h0, 1'b0, "R3 back inside");
    conv(3, 12'hFF0, 3, 2'd0, 16'h0100, 1'b0, "R8 write at end cycle masks");
    conv(3, 12'h500, 0, 2'd0, 16'h0, 1'b0, "R9 mask released");
    conv(4, 12'hA00, 1, 2'd1, 16'h0800, 1'b0, "R9 start-cycle write not masked");
    conv(4, 12'h500, 2, 2'd1, 16'h0900, 1'b0, "R10 masked write keeps out high");
    conv(4, 12'hF00, 0, 2'd0, 16'h0, 1'b1, "R5 clear loses to new event");

    wrReg(2'd3, 16'h0000);
    clrPulse();
    conv(4, 12'hF00, 0, 2'd0, 16'h0, 1'b0, "R6 irq disabled, R11 control bit");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d results missing, expected 0", expQ.size());
    end
    printSummary();
    $finish;
  end
endmodule